// File: doc/BRIEF.md
# Cascaded Successive Running-Sum Integrator

This block keeps twelve sliding-window totals of one detector channel's stream of unsigned loss samples. Each total is maintained incrementally: when a new entry arrives it is added to an accumulator, and the entry that falls out of the window is subtracted. The entry that falls out is read from a tap on a shared delay line. Several window lengths share one delay line. Each length is served by its own tap and its own accumulator.

Long windows come from five cascaded stages. The first stage stores raw samples. Every later stage stores partial totals. Each partial total is the value of one window of the stage before it, taken once that window's contents have been entirely replaced, so consecutive entries never overlap. No extra adder produces these partial totals: the feeding window's own accumulator supplies them. Depths are parameters. The defaults are scaled down so that a short simulation can fill even the longest window.

Sample data is offered with a one-cycle strobe. Each of the twelve totals carries its own one-cycle update strobe. That strobe stays low until the window has been filled once.

Top module: `srs_cascade`

## Requirements
- R1: After a sample strobe is captured, sum 0 (window of one sample) equals that sample zero-extended, and its strobe is high on the following cycle.
- R2: Sum index j covers the last L samples, with L in index order 1, 2, 8, 16, 32, 64, 128, 256, 256, 512, 512, 1024 (indices 0-3 first stage, 4-5 second, 6-7 third, 8-9 fourth, 10-11 fifth). Whenever its strobe is high, it equals the exact total of those samples.
- R3: Stages two to five take one entry per 2, 32, 128 and 256 samples. The fed value is the non-overlapping partial sum from sums 1, 4, 6 and 8 respectively. Stage k's strobes rise k-1 cycles after the cycle in which R1's strobe rises for the completing sample.
- R4: A sum's strobe stays low until at least L samples have been taken since reset.
- R5: Within one stage, the strobe of a longer window is never high unless the strobe of every shorter window of that stage is high too.
- R6: Accumulators are 16 plus log2 of the longest window bits wide (26 by default), so 1024 consecutive samples of 0xFFFF give exactly 67107840.
- R7: Synchronous active-low reset clears all delay lines, sums and strobes. After release, every window fills again from zero.
- R8: A cycle without a sample strobe updates nothing: the first stage's strobes are low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | Sample strobe, one cycle per sample |
| smp_dat | input | SW (16) | Unsigned sample value |
| sum_o | output | 12 x AW (26) | Current window totals, index 0 shortest |
| sum_stb_o | output | 12 | Per-total update strobe |

## Verification
A stale delay-line entry or a wrong accumulator shows up as a wrong total at the very next strobe of the affected window. It does not wait for the window to be filled again. A feed counter that drifts breaks the spacing of the later stages' strobes within one refresh period of that stage. It also corrupts their totals, and this corruption persists until the bad entry leaves the window. A fill counter that is off by one moves the first strobe of a window by one entry period, and the first check after the fill boundary catches it.

// File: rtl/srs_pkg.sv
// Shared constants for the cascaded running-sum integrator.
// Assumes exactly five stages, with the first stage serving four windows
// and every later stage serving two.
package srs_pkg;
    localparam int NSTAGE = 5;
    localparam int NLATE  = NSTAGE - 1;
    localparam int NSUM   = 4 + 2 * NLATE;
endpackage

// File: rtl/srs_delay_line.sv
// Tapped delay line: shifts one entry per strobe and exposes, for each tap,
// the entry that is about to leave a window of that tap's length.
// Assumes TAPS increasing with the last tap equal to the depth; clears to zero.
module srs_delay_line #(
    parameter int W = 26,
    parameter int NTAP = 2,
    parameter logic [NTAP-1:0][15:0] TAPS = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift,
    input  logic [W-1:0]              din,
    output logic [NTAP-1:0][W-1:0]    leaving
);
    localparam int DEPTH = int'(TAPS[NTAP-1]);

    logic [W-1:0] line [DEPTH];

    // Shift register storage, zeroed on reset so the fill phase subtracts zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) line[i] <= '0;
        end else if (shift) begin
            line[0] <= din;
            for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
        end
    end

    // Tap outputs: oldest entry inside each window length.
    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        assign leaving[t] = line[int'(TAPS[t]) - 1];
    end
endmodule

// File: rtl/srs_stage.sv
// One integration stage: a tapped delay line plus one accumulator per tap.
// Emits per-window strobes once filled, and forwards the FEED window's
// total every TAPS[FEED] entries (a non-overlapping partial sum).
// Assumes accumulators are wide enough that no total exceeds W bits.
module srs_stage #(
    parameter int W = 26,
    parameter int NTAP = 2,
    parameter logic [NTAP-1:0][15:0] TAPS = '0,
    parameter int FEED = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_stb,
    input  logic [W-1:0]              in_dat,
    output logic [NTAP-1:0][W-1:0]    sum,
    output logic [NTAP-1:0]           sum_stb,
    output logic                      fwd_stb,
    output logic [W-1:0]              fwd_dat
);
    localparam int DEPTH = int'(TAPS[NTAP-1]);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int FLEN  = int'(TAPS[FEED]);
    localparam int FCW   = $clog2(FLEN + 1);

    logic [NTAP-1:0][W-1:0] leaving;
    logic [CW-1:0]          fill;
    logic [FCW-1:0]         fcnt;

    srs_delay_line #(.W(W), .NTAP(NTAP), .TAPS(TAPS)) u_line (
        .clk(clk), .rst_n(rst_n), .shift(in_stb), .din(in_dat), .leaving(leaving)
    );

    // Entry count since reset, saturating at the delay-line depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                               fill <= '0;
        else if (in_stb && int'(fill) != DEPTH)   fill <= fill + 1'b1;
    end

    // Per-tap running total and its filled-window update strobe.
    for (genvar t = 0; t < NTAP; t++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum[t]     <= '0;
                sum_stb[t] <= 1'b0;
            end else begin
                if (in_stb) sum[t] <= sum[t] + in_dat - leaving[t];
                sum_stb[t] <= in_stb && (int'(fill) >= int'(TAPS[t]) - 1);
            end
        end
    end

    // Read-delay counter: forward only after the feed window fully refreshed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt    <= '0;
            fwd_stb <= 1'b0;
        end else if (in_stb && int'(fcnt) == FLEN - 1) begin
            fcnt    <= '0;
            fwd_stb <= 1'b1;
        end else begin
            if (in_stb) fcnt <= fcnt + 1'b1;
            fwd_stb <= 1'b0;
        end
    end

    assign fwd_dat = sum[FEED];
endmodule

// File: rtl/srs_cascade.sv
// Top of the cascaded successive running-sum integrator for one channel.
// Stage 1 holds raw samples and serves four windows. Stages 2-5 each hold
// partial totals forwarded by the previous stage and serve two windows.
// Assumes taps increase within each stage; widths follow from the longest window.
module srs_cascade
    import srs_pkg::*;
#(
    parameter int SW   = 16,
    parameter int T1_0 = 1,
    parameter int T1_1 = 2,
    parameter int T1_2 = 8,
    parameter int T1_3 = 16,
    parameter int S2_A = 16,
    parameter int S2_B = 32,
    parameter int S3_A = 4,
    parameter int S3_B = 8,
    parameter int S4_A = 2,
    parameter int S4_B = 4,
    parameter int S5_A = 2,
    parameter int S5_B = 4,
    localparam int P2     = T1_1,
    localparam int P3     = P2 * S2_A,
    localparam int P4     = P3 * S3_A,
    localparam int P5     = P4 * S4_A,
    localparam int MAXWIN = P5 * S5_B,
    localparam int AW     = SW + $clog2(MAXWIN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_stb,
    input  logic [SW-1:0]           smp_dat,
    output logic [NSUM-1:0][AW-1:0] sum_o,
    output logic [NSUM-1:0]         sum_stb_o
);
    localparam logic [NLATE-1:0][15:0] LA = {16'(S5_A), 16'(S4_A), 16'(S3_A), 16'(S2_A)};
    localparam logic [NLATE-1:0][15:0] LB = {16'(S5_B), 16'(S4_B), 16'(S3_B), 16'(S2_B)};

    logic [NSTAGE-1:0]         chain_stb;
    logic [NSTAGE-1:0][AW-1:0] chain_dat;
    logic [AW-1:0]             smp_ext;

    assign smp_ext = {{(AW - SW){1'b0}}, smp_dat};

    // First stage: raw samples, forwards its two-sample window.
    srs_stage #(
        .W(AW), .NTAP(4),
        .TAPS({16'(T1_3), 16'(T1_2), 16'(T1_1), 16'(T1_0)}),
        .FEED(1)
    ) u_first (
        .clk(clk), .rst_n(rst_n), .in_stb(smp_stb), .in_dat(smp_ext),
        .sum(sum_o[3:0]), .sum_stb(sum_stb_o[3:0]),
        .fwd_stb(chain_stb[0]), .fwd_dat(chain_dat[0])
    );

    // Later stages: each fed by the shorter window of the stage before.
    for (genvar s = 0; s < NLATE; s++) begin : g_late
        srs_stage #(
            .W(AW), .NTAP(2), .TAPS({LB[s], LA[s]}), .FEED(0)
        ) u_stage (
            .clk(clk), .rst_n(rst_n),
            .in_stb(chain_stb[s]), .in_dat(chain_dat[s]),
            .sum(sum_o[4 + 2*s +: 2]), .sum_stb(sum_stb_o[4 + 2*s +: 2]),
            .fwd_stb(chain_stb[s+1]), .fwd_dat(chain_dat[s+1])
        );
    end
endmodule

// File: rtl/srs_cascade_chk.sv
// Assertion checker for srs_cascade, attached by bind below.
// Assumes default stage layout: sums 0-3 first stage, then pairs per stage.
module srs_cascade_chk
    import srs_pkg::*;
#(
    parameter int SW = 16,
    parameter int AW = 26
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_stb,
    input logic [SW-1:0]           smp_dat,
    input logic [NSUM-1:0][AW-1:0] sum_o,
    input logic [NSUM-1:0]         sum_stb_o,
    input logic                    tail_stb,
    input logic [AW-1:0]           tail_dat
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (sum_stb_o == '0 && sum_o == '0)); // R7

    AST_FIRST_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> (sum_stb_o[0] && sum_o[0] == {{(AW - SW){1'b0}}, $past(smp_dat)})); // R1

    AST_IDLE_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> (sum_stb_o[3:0] == '0)); // R8

    AST_FEED_ON_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        tail_stb |-> (sum_stb_o[NSUM-2] && tail_dat == sum_o[NSUM-2])); // R3

    for (genvar s = 0; s < NLATE; s++) begin : g_order
        localparam int SRC = (s == 0) ? 1 : 4 + 2 * (s - 1);
        AST_CASCADE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            sum_stb_o[4 + 2*s] |-> $past(sum_stb_o[SRC])); // R3
    end

    for (genvar j = 0; j < NSUM - 1; j++) begin : g_nest
        if ((j < 3) || (j >= 4 && (j % 2) == 0)) begin : g_pair
            AST_TAP_NESTING: assert property (@(posedge clk) disable iff (!rst_n)
                sum_stb_o[j+1] |-> sum_stb_o[j]); // R5
        end
    end
endmodule

bind srs_cascade srs_cascade_chk #(.SW(SW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_dat(smp_dat),
    .sum_o(sum_o), .sum_stb_o(sum_stb_o),
    .tail_stb(chain_stb[NSTAGE-1]), .tail_dat(chain_dat[NSTAGE-1])
);

// File: tb/sim_srs_cascade.sv
// Self-checking bench: behavioural prefix-sum model compared every clock.
module sim_srs_cascade;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 16;
    localparam int AW = 26;
    localparam int NS = 12;
    localparam int WIN [NS] = '{1, 2, 8, 16, 32, 64, 128, 256, 256, 512, 512, 1024};
    localparam int STG [NS] = '{0, 0, 0, 0, 1, 1, 2, 2, 3, 3, 4, 4};
    localparam int PER [5]  = '{1, 2, 32, 128, 256};

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  smp_stb = 1'b0;
    logic [SW-1:0]         smp_dat = '0;
    logic [NS-1:0][AW-1:0] sum_o;
    logic [NS-1:0]         sum_stb_o;

    int     checks = 0;
    int     fails = 0;
    bit     maxphase = 1'b0;
    longint pre[$];
    int     capn[$];

    srs_cascade u0 (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_dat(smp_dat),
        .sum_o(sum_o), .sum_stb_o(sum_stb_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Compare every output against the model after the latest edge.
    task automatic check_outputs();
        for (int j = 0; j < NS; j++) begin
            if (!rst_n) begin
                checks++;
                if (sum_stb_o[j] !== 1'b0 || sum_o[j] !== '0) begin
                    fails++;
                    $display("FAIL R7 sum%0d after reset: got stb=%0b val=%0d, expected stb=0 val=0",
                             j, sum_stb_o[j], sum_o[j]);
                end
            end else begin
                int     k = STG[j];
                int     idx = capn.size() - 1 - k;
                int     m = (idx >= 0) ? capn[idx] : 0;
                bit     due = (m > 0) && (m % PER[k] == 0);
                bit     exp_stb = due && (m >= WIN[j]);
                string  tag;
                checks++;
                if (sum_stb_o[j] !== exp_stb) begin
                    if (j == 0)              tag = exp_stb ? "R1" : "R8";
                    else if (due && m < WIN[j]) tag = "R4";
                    else if (k > 0)          tag = "R3";
                    else                     tag = "R2";
                    fails++;
                    $display("FAIL %s sum%0d strobe: got %0b, expected %0b (samples=%0d)",
                             tag, j, sum_stb_o[j], exp_stb, m);
                end else if (exp_stb) begin
                    longint ev = pre[m] - pre[m - WIN[j]];
                    checks++;
                    if (longint'(sum_o[j]) != ev) begin
                        tag = maxphase ? "R6" : ((j == 0) ? "R1" : "R2");
                        fails++;
                        $display("FAIL %s sum%0d value: got %0d, expected %0d", tag, j, sum_o[j], ev);
                    end
                end
            end
        end
        // R5: longer window of a stage only fires with every shorter one.
        for (int j = 0; j < NS - 1; j++) begin
            if (STG[j] == STG[j+1]) begin
                checks++;
                if (sum_stb_o[j+1] && !sum_stb_o[j]) begin
                    fails++;
                    $display("FAIL R5 sum%0d strobe without sum%0d: got 0, expected 1", j + 1, j);
                end
            end
        end
    endtask

    // One clock: drive at the falling edge, update model at the rising edge, then check.
    task automatic cycle(input bit r, input bit s, input logic [SW-1:0] d);
        rst_n   = r;
        smp_stb = s;
        smp_dat = d;
        @(posedge clk);
        if (!r) begin
            pre.delete();
            pre.push_back(0);
            capn.delete();
        end else begin
            if (s) pre.push_back(pre[pre.size() - 1] + longint'(d));
            capn.push_back(s ? pre.size() - 1 : 0);
        end
        @(negedge clk);
        check_outputs();
    endtask

    initial begin
        pre.push_back(0);
        repeat (3) cycle(1'b0, 1'b0, '0);
        // Continuous random samples: R1, R2, R3, R4.
        for (int i = 0; i < 1500; i++) cycle(1'b1, 1'b1, 16'($urandom));
        // Gapped strobes: R8 plus cascade under irregular spacing.
        for (int i = 0; i < 1200; i++) cycle(1'b1, ($urandom % 3) != 0, 16'($urandom));
        // Full-scale samples filling the longest window: R6.
        maxphase = 1'b1;
        for (int i = 0; i < 1100; i++) cycle(1'b1, 1'b1, 16'hFFFF);
        maxphase = 1'b0;
        // Mid-run reset, then refill from zero: R7, R4.
        repeat (2) cycle(1'b0, 1'b1, 16'h1234);
        for (int i = 0; i < 400; i++) cycle(1'b1, (i % 5) != 4, 16'(i * 37));
        repeat (8) cycle(1'b1, 1'b0, '0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired: got timeout, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule